// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Fall-Through Head

A single-clock FIFO with a parameterised data width and storage depth that runs in one of two personalities, picked by a mode pin captured while reset is held. In standard mode a word leaves the FIFO only when a read is requested, and the word shows up on the output register one edge after that read. The write-side flag goes low when the FIFO is full, and the read-side flag goes low when it is empty.

In fall-through mode the oldest word moves into an output register without being asked for. A low output-ready flag tells the consumer that the data outputs hold a valid word. A read consumes that word, and on the same edge the register reloads from storage when storage has another word. Because the output register is one more slot of storage, the FIFO holds DEPTH+1 words before the input-ready flag rises. After the last word has been consumed, the outputs keep showing it, and the output-ready flag reports that no new word is present.

Both flags change only on the rising clock edge. The two flag pins keep their meaning in each mode: the write-side pin gives full (low active) or input-ready (low active), and the read-side pin gives empty (low active) or output-ready (low active).

Top module: `dmf_fifo_top`

## Requirements
- R1: During reset the FIFO empties and captures the mode pin (0 = standard, 1 = fall-through). On leaving reset in standard mode the write flag is 1 and the read flag is 0. In fall-through mode the write flag is 0 and the read flag is 1.
- R2: In standard mode, when no reads follow reset, the write flag goes low on the edge of exactly the DEPTH-th write. Writes offered while it is low are dropped.
- R3: In standard mode the read flag is low whenever nothing is stored. A read offered then leaves the data outputs unchanged and removes nothing.
- R4: In standard mode an accepted read places the oldest word on the data outputs at that same clock edge, so words appear in write order.
- R5: In standard mode, a write and a read offered together on a full FIFO perform only the read. The write flag returns high and the offered word is lost.
- R6: In fall-through mode, when no reads follow reset, the write flag rises on the edge of the (DEPTH+1)-th write. Further writes are dropped until a read frees a slot.
- R7: In fall-through mode, a word written into an empty FIFO appears on the data outputs on the second edge after its write. The read flag falls on that same edge.
- R8: In fall-through mode the read flag stays low through the edge that moves the last stored word into the output register, and through idle cycles after it. It rises only on an edge where read enable is high.
- R9: After the last word has been consumed in fall-through mode, the data outputs keep that word. Reads offered while the read flag is high have no effect.
- R10: In fall-through mode, consecutive reads deliver one new word on every clock while storage holds words.
- R11: The mode pin is ignored outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_fwft_i | input | 1 | Mode select captured during reset: 0 standard, 1 fall-through |
| wr_en_i | input | 1 | Write request |
| wr_data_i | input | DATA_W | Write data |
| rd_en_i | input | 1 | Read request |
| rd_data_o | output | DATA_W | Output register data |
| wflag_n_o | output | 1 | Standard: full, low active. Fall-through: input-ready, low active |
| rflag_n_o | output | 1 | Standard: empty, low active. Fall-through: output-ready, low active |

## Verification
Writes and reads can arrive on the same edge. The cases that matter are a full FIFO in standard mode, where the write must lose, and an empty FIFO, where the read must be ignored while the write lands. The bench drives both requests together in those states. It then reads the FIFO dry to show which word survived. In fall-through mode a consuming read and the reload of the output register also share an edge. Back-to-back reads are judged by a fresh word on every clock and by the read flag staying low.

// File: rtl/dmf_pkg.sv
// Package: shared mode type for the dual-mode FIFO.
// Assumes: nothing beyond standard SystemVerilog.
package dmf_pkg;
    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } dmf_mode_e;
endpackage

// File: rtl/dmf_ram.sv
// Module: dmf_ram
// Storage array with one registered write port and a combinational read port.
// Assumes: the caller never writes a slot that is still waiting to be read.
module dmf_ram #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    parameter int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store the incoming word on an accepted write.
    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    // Present the slot at the read pointer.
    assign rdata = mem[raddr];
endmodule

// File: rtl/dmf_ptrs.sv
// Module: dmf_ptrs
// Read/write pointers, word count and registered full/empty of the storage array.
// Assumes: push is never raised when full and pop is never raised when empty.
module dmf_ptrs #(
    parameter int DEPTH = 8,
    parameter int AW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic          full,
    output logic          mem_empty
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nx;

    function automatic logic [AW-1:0] wrap_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Next occupancy from this cycle's push and pop.
    assign cnt_nx = cnt + CW'(push) - CW'(pop);

    // Advance pointers and register the status of the array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr      <= '0;
            rptr      <= '0;
            cnt       <= '0;
            full      <= 1'b0;
            mem_empty <= 1'b1;
        end else begin
            if (push) wptr <= wrap_inc(wptr);
            if (pop)  rptr <= wrap_inc(rptr);
            cnt       <= cnt_nx;
            full      <= (cnt_nx == CW'(DEPTH));
            mem_empty <= (cnt_nx == '0);
        end
    end

    // R2: the count never passes the array depth.
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(DEPTH));

    // R6: a full array with no pop stays full whatever is offered.
    a_r6_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> full);

    // R3: an empty array with no push stays empty.
    a_r3_empty_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_empty && !push) |=> mem_empty);
endmodule

// File: rtl/dmf_outstage.sv
// Module: dmf_outstage
// Output register and its load policy. Standard mode loads only on a read.
// Fall-through mode keeps the register filled and tracks whether it holds an unread word.
// Assumes: mem_data is the word at the read pointer, valid whenever mem_empty is low.
module dmf_outstage #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fwft,
    input  logic              rd_en,
    input  logic              mem_empty,
    input  logic [DATA_W-1:0] mem_data,
    output logic              pop,
    output logic [DATA_W-1:0] data_q,
    output logic              head_valid
);
    // Decide when a word leaves the array.
    always_comb begin
        if (fwft) pop = !mem_empty && (!head_valid || rd_en);
        else      pop = rd_en && !mem_empty;
    end

    // Load the output register and track an unread head word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q     <= '0;
            head_valid <= 1'b0;
        end else begin
            if (pop) data_q <= mem_data;
            if (fwft) begin
                if (pop)        head_valid <= 1'b1;
                else if (rd_en) head_valid <= 1'b0;
            end
        end
    end

    // R8: an unread head word stays until a read consumes it.
    a_r8_head_waits_for_read: assert property (@(posedge clk) disable iff (!rst_n)
        (fwft && head_valid && !rd_en) |=> head_valid);

    // R9: consuming the last word keeps it on the outputs.
    a_r9_stale_word_held: assert property (@(posedge clk) disable iff (!rst_n)
        (fwft && head_valid && rd_en && mem_empty) |=> (!head_valid && $stable(data_q)));

    // R3: a standard-mode read on an empty array leaves the outputs alone.
    a_r3_empty_read_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwft && mem_empty && rd_en) |=> $stable(data_q));
endmodule

// File: rtl/dmf_fifo_top.sv
// Module: dmf_fifo_top
// Dual-mode synchronous FIFO: standard read-on-request or first-word fall-through.
// The mode is captured during reset.
// Assumes: one clock domain, synchronous active-low reset, DEPTH >= 2.
module dmf_fifo_top
    import dmf_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_fwft_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              wflag_n_o,
    output logic              rflag_n_o
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    dmf_mode_e         mode_q;
    logic              fwft;
    logic              push, pop;
    logic              full, mem_empty, head_valid;
    logic [AW-1:0]     wptr, rptr;
    logic [DATA_W-1:0] mem_data;

    // Capture the mode only while reset is held (R11).
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= dmf_mode_e'(mode_fwft_i);
    end

    assign fwft = (mode_q == MODE_FWFT);
    assign push = wr_en_i && !full;

    dmf_ptrs #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ptrs (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
        .wptr(wptr), .rptr(rptr), .full(full), .mem_empty(mem_empty)
    );

    dmf_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_ram (
        .clk(clk), .we(push), .waddr(wptr), .wdata(wr_data_i),
        .raddr(rptr), .rdata(mem_data)
    );

    dmf_outstage #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst_n(rst_n), .fwft(fwft), .rd_en(rd_en_i),
        .mem_empty(mem_empty), .mem_data(mem_data), .pop(pop),
        .data_q(rd_data_o), .head_valid(head_valid)
    );

    // Map the registered status onto the mode-dependent flag pins.
    assign wflag_n_o = fwft ? full : !full;
    assign rflag_n_o = fwft ? !head_valid : !mem_empty;

    // R5: a standard-mode write and read together on a full FIFO free one slot.
    a_r5_read_wins_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        (!fwft && full && wr_en_i && rd_en_i) |=> !full);

    // R11: the captured mode does not change outside reset.
    a_r11_mode_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(mode_q));
endmodule

// File: tb/dmf_fifo_top_tb_top.sv
module dmf_fifo_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int DEP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] rd_data;
    logic          wflag_n, rflag_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmf_fifo_top #(.DATA_W(DW), .DEPTH(DEP)) dut_i (
        .clk(clk), .rst_n(rst_n), .mode_fwft_i(mode),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
        .rd_data_o(rd_data), .wflag_n_o(wflag_n), .rflag_n_o(rflag_n)
    );

    // Standard-mode vectors: {wr, rd, din[8], exp_wflag, exp_rflag, chk_data, exp_data[8]}
    localparam logic [20:0] VEC [12] = '{
        {1'b1, 1'b0, 8'h11, 1'b1, 1'b1, 1'b0, 8'h00},  // R2 write 1
        {1'b1, 1'b0, 8'h12, 1'b1, 1'b1, 1'b0, 8'h00},  // R2 write 2
        {1'b1, 1'b0, 8'h13, 1'b1, 1'b1, 1'b0, 8'h00},  // R2 write 3
        {1'b1, 1'b0, 8'h14, 1'b0, 1'b1, 1'b0, 8'h00},  // R2 full after DEPTH writes
        {1'b1, 1'b0, 8'h15, 1'b0, 1'b1, 1'b0, 8'h00},  // R2 write while full dropped
        {1'b1, 1'b1, 8'h16, 1'b1, 1'b1, 1'b1, 8'h11},  // R5 read wins on full
        {1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1, 8'h12},  // R4 order
        {1'b0, 1'b1, 8'h00, 1'b1, 1'b1, 1'b1, 8'h13},  // R4 order
        {1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 8'h14},  // R4/R5 last word, 15 and 16 lost
        {1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 8'h14},  // R3 read on empty ignored
        {1'b1, 1'b1, 8'h21, 1'b1, 1'b1, 1'b1, 8'h14},  // R3 empty read ignored, write lands
        {1'b0, 1'b1, 8'h00, 1'b1, 1'b0, 1'b1, 8'h21}   // R4 read back
    };

    task automatic check(input string req, input logic [DW+1:0] act, input logic [DW+1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got flags/data %h, expected %h", req, act, exp);
        end
    endtask

    // Drive between edges, pass one rising edge, sample at the falling edge.
    task automatic step(input logic w, input logic [DW-1:0] d, input logic r);
        wr_en = w; wr_data = d; rd_en = r;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic do_reset(input logic m);
        rst_n = 1'b0; mode = m;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        @(negedge clk);
        // R1: standard mode reset values.
        do_reset(1'b0);
        mode = 1'b1;  // R11: must be ignored from here on
        check("R1 std reset", {wflag_n, rflag_n, rd_data}, {1'b1, 1'b0, 8'h00});

        for (int i = 0; i < 12; i++) begin
            step(VEC[i][20], VEC[i][18:11], VEC[i][19]);
            if (VEC[i][8])
                check($sformatf("R2-5/R11 vec %0d", i), {wflag_n, rflag_n, rd_data},
                      {VEC[i][10], VEC[i][9], VEC[i][7:0]});
            else
                check($sformatf("R2/R11 vec %0d", i), {wflag_n, rflag_n, 8'h00},
                      {VEC[i][10], VEC[i][9], 8'h00});
        end

        // Fall-through mode directed tests.
        do_reset(1'b1);
        mode = 1'b0;  // R11
        check("R1 fwft reset", {wflag_n, rflag_n, 8'h00}, {1'b0, 1'b1, 8'h00});
        step(1'b1, 8'hA0, 1'b0);
        check("R7 not yet valid", {wflag_n, rflag_n, 8'h00}, {1'b0, 1'b1, 8'h00});
        step(1'b0, 8'h00, 1'b0);
        check("R7 head valid", {wflag_n, rflag_n, rd_data}, {1'b0, 1'b0, 8'hA0});
        step(1'b1, 8'hA1, 1'b0);
        step(1'b1, 8'hA2, 1'b0);
        step(1'b1, 8'hA3, 1'b0);
        check("R6 room after DEPTH writes", {wflag_n, rflag_n, rd_data}, {1'b0, 1'b0, 8'hA0});
        step(1'b1, 8'hA4, 1'b0);
        check("R6 blocked after DEPTH+1", {wflag_n, rflag_n, rd_data}, {1'b1, 1'b0, 8'hA0});
        step(1'b1, 8'hA5, 1'b0);
        check("R6 write dropped", {wflag_n, rflag_n, rd_data}, {1'b1, 1'b0, 8'hA0});
        for (int k = 1; k <= 4; k++) begin
            step(1'b0, 8'h00, 1'b1);
            check("R10 streaming read", {wflag_n, rflag_n, rd_data}, {1'b0, 1'b0, 8'(8'hA0 + k)});
        end
        step(1'b0, 8'h00, 1'b0);
        check("R8 idle keeps ready", {wflag_n, rflag_n, rd_data}, {1'b0, 1'b0, 8'hA4});
        step(1'b0, 8'h00, 1'b1);
        check("R8/R9 last read", {wflag_n, rflag_n, rd_data}, {1'b0, 1'b1, 8'hA4});
        step(1'b0, 8'h00, 1'b1);
        check("R9 read with no word", {wflag_n, rflag_n, rd_data}, {1'b0, 1'b1, 8'hA4});

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule